// File: doc/BRIEF.md
# Exception Entry and Privilege Mode Unit

This unit holds the trap state of a small 32-bit processor. Every cycle it inspects the instruction in the trap stage for three kinds of event: a pending interrupt, a coprocessor instruction issued without privilege, and a memory access from user code into the kernel half of the address space. When one of them is taken, the unit does four things in the same cycle:

- It raises a fetch redirect to a fixed handler address.
- It captures the restart address.
- It records a 4-bit reason code together with a delay-slot flag.
- It pushes the kernel/interrupt-enable pair onto a two-entry stack, so that the core runs in kernel mode with interrupts masked.

A return-from-exception strobe pops that stack. Software then jumps to the saved restart address.

At reset the current pair is kernel mode with interrupts off. The previous pair is user mode with interrupts on. A boot routine therefore enters user code with a single return-from-exception.

Top module: `excUnit`

## Requirements
- R1: On a taken exception, the saved restart address becomes `instrPc`. If `inDelaySlot` is high, it becomes `branchPc` instead. It is visible on `epc` after the clock edge.
- R2: After a taken exception, `kernelMode` is 1 and `irqEnable` is 0. The pair that was current before the exception becomes the previous pair.
- R3: In the cycle an exception is taken, `excTaken` is 1 and `redirectPc` is 0x80000080. In every other cycle `excTaken` is 0 and `redirectPc` is 0.
- R4: A taken exception writes `causeCode` and writes `causeBd` (1 when in a delay slot). `causeCode`, `causeBd` and `epc` keep their values in cycles with no exception.
- R5: In user mode, a `memValid` access with `memAddr` at or above 0x80000000 raises cause 4 for a load (`memWrite`=0) or cause 5 for a store. Addresses below that boundary, and any address in kernel mode, raise nothing.
- R6: In user mode, `copInstr` raises cause 11. In kernel mode it raises nothing.
- R7: `irqReq` raises cause 0 only while `irqEnable` is 1. With `irqEnable` at 0 it is ignored.
- R8: When several causes are present in one cycle, the order is interrupt, then coprocessor fault, then address error.
- R9: `rfeOp` copies the previous pair into the current pair. If an exception is taken in the same cycle, the exception wins and the return is dropped.
- R10: After reset: `kernelMode`=1, `irqEnable`=0, `epc`=0, `causeCode`=0, `causeBd`=0. The previous pair is user mode with interrupts enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrPc | input | 32 | Address of the instruction in the trap stage |
| branchPc | input | 32 | Address of the branch owning the delay slot |
| inDelaySlot | input | 1 | Trap-stage instruction sits in a branch delay slot |
| memValid | input | 1 | Trap-stage instruction makes a data access |
| memWrite | input | 1 | The access is a store (0 = load) |
| memAddr | input | 32 | Virtual data address |
| copInstr | input | 1 | Trap-stage instruction is a coprocessor operation |
| irqReq | input | 1 | External interrupt request |
| rfeOp | input | 1 | Return-from-exception strobe |
| excTaken | output | 1 | An exception is taken this cycle |
| redirectPc | output | 32 | Handler address while `excTaken`, else 0 |
| epc | output | 32 | Saved restart address |
| causeCode | output | 4 | Reason of the last exception |
| causeBd | output | 1 | Last exception was in a delay slot |
| kernelMode | output | 1 | Current privilege (1 = kernel) |
| irqEnable | output | 1 | Current interrupt enable |

## Verification
Data accesses are tried on both sides of the kernel boundary (0x7FFFFFFC and 0x80000000), near the top of memory, and in both modes. This separates a range check on the top address bit from one that tests the mode, and tells load codes from store codes. Interrupt requests are applied with the enable both clear and set, which shows that masking affects only asynchronous causes. Combined cause patterns expose the priority order. A delay-slot fault shows that the branch address is chosen for the restart. A return issued together with a fault shows that entry wins over the pop.

// File: rtl/excPkg.sv
package excPkg;

  typedef enum logic [3:0] {
    EXC_IRQ    = 4'd0,
    EXC_LDADDR = 4'd4,
    EXC_STADDR = 4'd5,
    EXC_NOCOP  = 4'd11
  } causeE;

  typedef struct packed {
    logic kernel;
    logic ie;
  } modePairT;

  typedef struct packed {
    logic  take;
    logic  pop;
    logic  bd;
    causeE code;
  } strobeT;

endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] KBASE = 32'h8000_0000
) (
  input  modePairT          curPair,
  input  logic              irqReq,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              copInstr,
  input  logic              inDelaySlot,
  input  logic              rfeOp,
  output strobeT            stb
);

  logic userMode;
  logic irqHit;
  logic copHit;
  logic adrHit;

  always_comb begin
    userMode = !curPair.kernel;
    irqHit   = irqReq && curPair.ie;
    copHit   = userMode && copInstr;
    adrHit   = userMode && memValid && (memAddr >= KBASE);

    stb      = '0;
    stb.code = EXC_IRQ;
    if (irqHit)      stb.code = EXC_IRQ;
    else if (copHit) stb.code = EXC_NOCOP;
    else if (adrHit) stb.code = memWrite ? EXC_STADDR : EXC_LDADDR;

    stb.take = irqHit || copHit || adrHit;
    stb.pop  = rfeOp && !stb.take;
    stb.bd   = inDelaySlot;
  end

endmodule

// File: rtl/excRegs.sv
module excRegs
  import excPkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter bit RESET_PREV_KERNEL = 1'b0,
  parameter bit RESET_PREV_IE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] instrPc,
  input  logic [ADDR_W-1:0] branchPc,
  output logic [ADDR_W-1:0] epc,
  output logic [3:0]        causeCode,
  output logic              causeBd,
  output modePairT          curPair,
  output modePairT          prevPair
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPair.kernel  <= 1'b1;
      curPair.ie      <= 1'b0;
      prevPair.kernel <= RESET_PREV_KERNEL;
      prevPair.ie     <= RESET_PREV_IE;
      epc             <= '0;
      causeCode       <= '0;
      causeBd         <= 1'b0;
    end else if (stb.take) begin
      epc            <= stb.bd ? branchPc : instrPc;
      causeCode      <= stb.code;
      causeBd        <= stb.bd;
      prevPair       <= curPair;
      curPair.kernel <= 1'b1;
      curPair.ie     <= 1'b0;
    end else if (stb.pop) begin
      curPair <= prevPair;
    end
  end

endmodule

// File: rtl/excUnit.sv
module excUnit
  import excPkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] VECTOR = 32'h8000_0080,
  parameter logic [ADDR_W-1:0] KBASE = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] instrPc,
  input  logic [ADDR_W-1:0] branchPc,
  input  logic              inDelaySlot,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              copInstr,
  input  logic              irqReq,
  input  logic              rfeOp,
  output logic              excTaken,
  output logic [ADDR_W-1:0] redirectPc,
  output logic [ADDR_W-1:0] epc,
  output logic [3:0]        causeCode,
  output logic              causeBd,
  output logic              kernelMode,
  output logic              irqEnable
);

  strobeT   stb;
  modePairT curPair;
  modePairT prevPair;

  excCtrl #(.ADDR_W(ADDR_W), .KBASE(KBASE)) u_ctrl (
    .curPair(curPair), .irqReq(irqReq), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .copInstr(copInstr),
    .inDelaySlot(inDelaySlot), .rfeOp(rfeOp), .stb(stb)
  );

  excRegs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .instrPc(instrPc),
    .branchPc(branchPc), .epc(epc), .causeCode(causeCode),
    .causeBd(causeBd), .curPair(curPair), .prevPair(prevPair)
  );

  assign excTaken   = stb.take;
  assign redirectPc = stb.take ? VECTOR : '0;
  assign kernelMode = curPair.kernel;
  assign irqEnable  = curPair.ie;

endmodule

// File: rtl/excUnitChk.sv
module excUnitChk #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] VEC = 32'h8000_0080
) (
  input logic              clk,
  input logic              rstN,
  input logic              excTaken,
  input logic              inDelaySlot,
  input logic [ADDR_W-1:0] instrPc,
  input logic [ADDR_W-1:0] branchPc,
  input logic              irqReq,
  input logic              memValid,
  input logic              copInstr,
  input logic              rfeOp,
  input logic [ADDR_W-1:0] epc,
  input logic [3:0]        causeCode,
  input logic              causeBd,
  input logic              kernelMode,
  input logic              irqEnable,
  input logic [ADDR_W-1:0] redirectPc,
  input logic [1:0]        prevBits
);

  p_epc_save_r1: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |=> epc == ($past(inDelaySlot) ? $past(branchPc) : $past(instrPc)));

  p_enter_kernel_r2: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |=> (kernelMode && !irqEnable));

  p_push_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |=> prevBits == $past({kernelMode, irqEnable}));

  p_vector_r3: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> redirectPc == VEC);

  p_cause_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !excTaken |=> ($stable(causeCode) && $stable(causeBd) && $stable(epc)));

  p_kernel_safe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (kernelMode && !(irqReq && irqEnable)) |-> !excTaken);

  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEnable && !memValid && !copInstr) |-> !excTaken);

  p_rfe_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rfeOp && !excTaken) |=> {kernelMode, irqEnable} == $past(prevBits));

endmodule

bind excUnit excUnitChk #(.ADDR_W(ADDR_W), .VEC(VECTOR)) u_chk (
  .clk(clk), .rstN(rstN), .excTaken(excTaken), .inDelaySlot(inDelaySlot),
  .instrPc(instrPc), .branchPc(branchPc), .irqReq(irqReq),
  .memValid(memValid), .copInstr(copInstr), .rfeOp(rfeOp), .epc(epc),
  .causeCode(causeCode), .causeBd(causeBd), .kernelMode(kernelMode),
  .irqEnable(irqEnable), .redirectPc(redirectPc), .prevBits(prevPair)
);

// File: tb/sim_excUnit.sv
module sim_excUnit;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic [31:0] instrPc, branchPc, memAddr;
  logic        inDelaySlot, memValid, memWrite, copInstr, irqReq, rfeOp;
  logic        excTaken, causeBd, kernelMode, irqEnable;
  logic [31:0] redirectPc, epc;
  logic [3:0]  causeCode;

  int nChecks = 0;
  int nFails  = 0;

  bit          mK, mIe, pK, pIe, mBd;
  logic [31:0] mEpc;
  logic [3:0]  mCause;

  excUnit u0 (
    .clk(clk), .rstN(rstN), .instrPc(instrPc), .branchPc(branchPc),
    .inDelaySlot(inDelaySlot), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .copInstr(copInstr), .irqReq(irqReq), .rfeOp(rfeOp),
    .excTaken(excTaken), .redirectPc(redirectPc), .epc(epc),
    .causeCode(causeCode), .causeBd(causeBd), .kernelMode(kernelMode),
    .irqEnable(irqEnable)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkRegs(string req);
    chk(req, "epc", epc, mEpc);
    chk(req, "causeCode", {28'd0, causeCode}, {28'd0, mCause});
    chk(req, "causeBd", {31'd0, causeBd}, {31'd0, mBd});
    chk(req, "kernelMode", {31'd0, kernelMode}, {31'd0, mK});
    chk(req, "irqEnable", {31'd0, irqEnable}, {31'd0, mIe});
  endtask

  task automatic step(string req, logic [31:0] pc, logic [31:0] bpc, bit ds,
                      bit mv, bit mw, logic [31:0] ma, bit cop, bit irq, bit rfe);
    bit take;
    bit [3:0] code;
    instrPc = pc; branchPc = bpc; inDelaySlot = ds; memValid = mv;
    memWrite = mw; memAddr = ma; copInstr = cop; irqReq = irq; rfeOp = rfe;
    take = 1'b0;
    code = 4'd0;
    if (irq && mIe) begin
      take = 1'b1; code = 4'd0;
    end else if (!mK && cop) begin
      take = 1'b1; code = 4'd11;
    end else if (!mK && mv && ma >= 32'h8000_0000) begin
      take = 1'b1; code = mw ? 4'd5 : 4'd4;
    end
    #1;
    chk(req, "excTaken", {31'd0, excTaken}, {31'd0, take});
    chk("R3", "redirectPc", redirectPc, take ? 32'h8000_0080 : 32'h0);
    @(posedge clk);
    if (take) begin
      mEpc = ds ? bpc : pc;
      mCause = code;
      mBd = ds;
      pK = mK; pIe = mIe;
      mK = 1'b1; mIe = 1'b0;
    end else if (rfe) begin
      mK = pK; mIe = pIe;
    end
    @(negedge clk);
    checkRegs(req);
  endtask

  task automatic idleRfe();
    step("R9", 32'h100, 32'h0, 0, 0, 0, 32'h0, 0, 0, 1);
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    instrPc = '0; branchPc = '0; memAddr = '0;
    inDelaySlot = 0; memValid = 0; memWrite = 0; copInstr = 0; irqReq = 0; rfeOp = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mK = 1; mIe = 0; pK = 0; pIe = 1; mBd = 0; mEpc = '0; mCause = '0;
    checkRegs("R10");

    // Kernel mode: masked interrupt, high address and coprocessor all harmless
    step("R7", 32'h0000_0010, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R5", 32'h0000_0014, 0, 0, 1, 0, 32'h8000_0000, 0, 0, 0);
    step("R6", 32'h0000_0018, 0, 0, 0, 0, 0, 1, 0, 0);
    // Enter user mode, interrupts on
    idleRfe();
    // Coprocessor fault from user code
    step("R2", 32'h0040_0020, 0, 0, 0, 0, 0, 1, 0, 0);
    idleRfe();
    // Load at boundary, store near top, load just below
    step("R5", 32'h0040_0024, 0, 0, 1, 0, 32'h8000_0000, 0, 0, 0);
    idleRfe();
    step("R5", 32'h0040_0028, 0, 0, 1, 1, 32'hFFFF_FFFC, 0, 0, 0);
    idleRfe();
    step("R5", 32'h0040_002C, 0, 0, 1, 0, 32'h7FFF_FFFC, 0, 0, 0);
    // Delay-slot store fault saves branch address
    step("R1", 32'h0040_0034, 32'h0040_0030, 1, 1, 1, 32'h9000_0000, 0, 0, 0);
    idleRfe();
    // Priority: all three causes, then coprocessor plus address
    step("R8", 32'h0040_0040, 0, 0, 1, 0, 32'hA000_0000, 1, 1, 0);
    idleRfe();
    step("R8", 32'h0040_0044, 0, 0, 1, 1, 32'hA000_0000, 1, 0, 0);
    idleRfe();
    // Return issued with a fault: entry wins
    step("R9", 32'h0040_0048, 0, 0, 0, 0, 0, 1, 0, 1);
    idleRfe();
    // Plain interrupt in user mode
    step("R7", 32'h0040_004C, 0, 0, 0, 0, 0, 0, 1, 0);
    // Nothing happens: cause and epc hold
    step("R4", 32'h0000_0050, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 32'h0000_0054, 0, 1, 0, 0, 0, 0, 1, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule